// File: doc/BRIEF.md
# Memory Map Configuration Register with Address Decode

This block holds the memory-map configuration of an 8-bit microcontroller with a 24-bit address space and turns it into address-decode strobes. A single configuration byte places the 4 kB internal SRAM in one of three windows and marks whether that SRAM also serves instruction fetches. It places the pair of 256-byte CAN message buffers low or high in the map, and it selects whether external data reads use the program-fetch strobe instead of the data read strobe. A companion register holds the wide-stack-pointer enable bit.

Both registers can be read at any time. They change only through a timed-access sequence: the key 0xAA and then the key 0x55 written to the unlock address on back-to-back clock cycles open a short window in which a single protected write lands. An interlock keeps the unified program/data SRAM mode and the wide stack mode from ever being on together. If a write would combine them, that part of the write is dropped.

The decode side is purely combinational from the bus address, the fetch/data qualifier and the read qualifier. It asserts at most one internal select and routes every access that misses the internal windows to the correct external strobe.

Top module: `memmap_cfg`

## Requirements
- R1: After reset the configuration register reads 0x10 and the stack register reads 0x00. Register addresses: configuration 0x20, stack 0x21, unlock 0x22. Reads of any other address return 0x00.
- R2: Configuration byte layout: bits 7:6 are the SRAM mode, bit 5 is CAN placement, bit 3 is merged chip enable. Bit 4 always reads 1, and bits 2:0 always read 0, whatever is written. The stack register holds the wide-stack enable in bit 0, and its bits 7:1 read 0.
- R3: A write to either register changes nothing unless the timed-access window is open. The window opens when 0xAA is written to the unlock address on one cycle and 0x55 is written to the unlock address on the very next cycle.
- R4: The window lasts 4 cycles after the 0x55 write. Any write performed while it is open closes it, so at most one protected write lands per unlock. A gap between the two keys, or a key written to another address, opens nothing.
- R5: A protected configuration write that sets the SRAM mode to 11 while the wide-stack bit is 1 leaves the SRAM mode unchanged. The CAN placement and merged chip-enable bits from the same write still take effect.
- R6: A protected write that sets the wide-stack bit while the SRAM mode is 11 leaves the bit at 0. Clearing the bit is always accepted.
- R7: The SRAM data select asserts for a data access in the window given by the mode: 00 selects 0x00F000–0x00FFFF, 01 selects 0x000000–0x000FFF, and 10 or 11 select 0x400000–0x400FFF.
- R8: The SRAM program select asserts only for an instruction fetch in 0x400000–0x400FFF while the mode is 11. A fetch never asserts a data select.
- R9: With CAN placement 0, buffer 0 decodes at 0x00EE00–0x00EEFF and buffer 1 at 0x00EF00–0x00EFFF. With placement 1 they decode at 0x401000–0x4010FF and 0x401100–0x4011FF. Only data accesses select them.
- R10: An external data read (a read that hits no internal window) asserts the program-fetch strobe when merged chip enable is 1 and the port-enable input is 1. Otherwise it asserts the data read strobe. An external data write asserts neither strobe.
- R11: A fetch that does not hit the program select asserts the program-fetch strobe. Any access that hits an internal select asserts no external strobe, and nothing asserts while the bus request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| bus_req | input | 1 | Bus access valid |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_rd | input | 1 | 1 = data read, 0 = data write (ignored for fetches) |
| bus_addr | input | 24 | Bus address |
| ce_port_en | input | 1 | Port control reports the merged chip enable pin as enabled |
| wide_stack | output | 1 | Wide stack pointer mode enable |
| sram_data_sel | output | 1 | Internal SRAM data select |
| sram_code_sel | output | 1 | Internal SRAM program select |
| can_sel | output | 2 | CAN buffer selects, bit i for buffer i |
| ext_rd_stb | output | 1 | External data read strobe |
| ext_psen_stb | output | 1 | External program-fetch strobe |

## Verification
The hardest states to reach are the two interlock refusals. Each one needs two separate unlocked writes: the first puts the opposing mode in place, and the second tries to enable the conflicting one. The bench follows that exact order. It then checks through the read port that only the refused field stayed put and that the other bits of the same write landed. The window edge is reached by idling a counted number of cycles after the second key, both one cycle short of expiry and at expiry. The decode is swept over every mode, CAN placement and strobe-gating combination, across every 256-byte page of three address banks.

// File: rtl/memmap_pkg.sv
// Shared types and constants for the memory-map configuration block.
// Assumes a byte-wide register interface and 4 kB SRAM blocks.
package memmap_pkg;

    typedef enum logic [1:0] {
        SRAM_TOP_LOW = 2'b00,
        SRAM_ZERO    = 2'b01,
        SRAM_HIGH    = 2'b10,
        SRAM_UNIFIED = 2'b11
    } sram_mode_e;

    typedef struct packed {
        sram_mode_e sram;
        logic       can_hi;
        logic       merged_ce;
    } mm_cfg_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    // Pack the configuration fields into their readable byte image.
    function automatic logic [7:0] cfg_to_byte(input mm_cfg_t c);
        return {c.sram, c.can_hi, 1'b1, c.merged_ce, 3'b000};
    endfunction

endpackage

// File: rtl/mm_unlock.sv
// Timed-access sequencer: a first key followed on the next cycle by a second
// key, both written to the unlock address, opens a window of WIN_CYCLES
// cycles. Any write while the window is open closes it.
// Assumes wr_en is one cycle per write.
module mm_unlock #(
    parameter int         REG_AW      = 8,
    parameter logic [7:0] UNLOCK_ADDR = 8'h22,
    parameter int         WIN_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              win_open
);
    import memmap_pkg::*;

    localparam int CNT_W = $clog2(WIN_CYCLES + 1);

    logic             key1_seen;
    logic [CNT_W-1:0] win_cnt;
    logic             at_unlock;

    assign at_unlock = wr_en && (wr_addr == REG_AW'(UNLOCK_ADDR));

    // Track the key sequence and count down the open window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key1_seen <= 1'b0;
            win_cnt   <= '0;
        end else begin
            key1_seen <= at_unlock && (wr_data == KEY_FIRST);
            if (at_unlock && wr_data == KEY_FIRST) begin
                win_cnt <= '0;
            end else if (at_unlock && key1_seen && wr_data == KEY_SECOND) begin
                win_cnt <= CNT_W'(WIN_CYCLES);
            end else if (wr_en) begin
                win_cnt <= '0;
            end else if (win_cnt != '0) begin
                win_cnt <= win_cnt - 1'b1;
            end
        end
    end

    assign win_open = (win_cnt != '0);

endmodule

// File: rtl/mm_regs.sv
// Configuration and stack-mode registers with the mode interlock.
// Writes land only while win_open is high. Unified SRAM mode and the wide
// stack bit can never be 1 together; a conflicting field is left unchanged.
module mm_regs #(
    parameter int         REG_AW   = 8,
    parameter logic [7:0] CFG_ADDR = 8'h20,
    parameter logic [7:0] STK_ADDR = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 win_open,
    output memmap_pkg::mm_cfg_t  cfg,
    output logic                 wide_stack
);
    import memmap_pkg::*;

    logic       cfg_wr;
    logic       stk_wr;
    sram_mode_e new_mode;

    assign cfg_wr   = wr_en && win_open && (wr_addr == REG_AW'(CFG_ADDR));
    assign stk_wr   = wr_en && win_open && (wr_addr == REG_AW'(STK_ADDR));
    assign new_mode = sram_mode_e'(wr_data[7:6]);

    // Configuration register update, with the SRAM-mode half of the interlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.sram      <= SRAM_TOP_LOW;
            cfg.can_hi    <= 1'b0;
            cfg.merged_ce <= 1'b0;
        end else if (cfg_wr) begin
            cfg.can_hi    <= wr_data[5];
            cfg.merged_ce <= wr_data[3];
            if (!(new_mode == SRAM_UNIFIED && wide_stack)) begin
                cfg.sram <= new_mode;
            end
        end
    end

    // Stack-mode bit update, with the stack half of the interlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_stack <= 1'b0;
        end else if (stk_wr) begin
            wide_stack <= wr_data[0] && (cfg.sram != SRAM_UNIFIED);
        end
    end

endmodule

// File: rtl/mm_decode.sv
// Combinational address decode: SRAM data/program selects, CAN buffer
// selects and the external strobe choice. Assumes 4 kB SRAM blocks and
// 256-byte CAN pages placed consecutively from a base page.
module mm_decode #(
    parameter int          ADDR_W      = 24,
    parameter int          NUM_CAN     = 2,
    parameter logic [11:0] SRAM_BLK_TOP  = 12'h00F,
    parameter logic [11:0] SRAM_BLK_ZERO = 12'h000,
    parameter logic [11:0] SRAM_BLK_HIGH = 12'h400,
    parameter logic [15:0] CAN_PAGE_LO = 16'h00EE,
    parameter logic [15:0] CAN_PAGE_HI = 16'h4010
) (
    input  memmap_pkg::mm_cfg_t cfg,
    input  logic                bus_req,
    input  logic                bus_fetch,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                ce_port_en,
    output logic                sram_data_sel,
    output logic                sram_code_sel,
    output logic [NUM_CAN-1:0]  can_sel,
    output logic                ext_rd_stb,
    output logic                ext_psen_stb
);
    import memmap_pkg::*;

    localparam int BLK_W  = ADDR_W - 12;
    localparam int PAGE_W = ADDR_W - 8;

    logic [BLK_W-1:0]  blk;
    logic [PAGE_W-1:0] page;
    logic [BLK_W-1:0]  sram_blk;
    logic [PAGE_W-1:0] can_base;
    logic              data_acc;
    logic              int_hit;
    logic              merged_eff;

    assign blk      = bus_addr[ADDR_W-1:12];
    assign page     = bus_addr[ADDR_W-1:8];
    assign data_acc = bus_req && !bus_fetch;

    // Pick the SRAM block number from the mode field.
    always_comb begin
        unique case (cfg.sram)
            SRAM_TOP_LOW: sram_blk = BLK_W'(SRAM_BLK_TOP);
            SRAM_ZERO:    sram_blk = BLK_W'(SRAM_BLK_ZERO);
            default:      sram_blk = BLK_W'(SRAM_BLK_HIGH);
        endcase
    end

    assign can_base = cfg.can_hi ? PAGE_W'(CAN_PAGE_HI) : PAGE_W'(CAN_PAGE_LO);

    assign sram_data_sel = data_acc && (blk == sram_blk);
    assign sram_code_sel = bus_req && bus_fetch && (cfg.sram == SRAM_UNIFIED)
                           && (blk == BLK_W'(SRAM_BLK_HIGH));

    // One consecutive 256-byte page per CAN buffer.
    for (genvar i = 0; i < NUM_CAN; i++) begin : g_can
        assign can_sel[i] = data_acc && (page == can_base + PAGE_W'(i));
    end

    assign int_hit    = sram_data_sel || (|can_sel);
    assign merged_eff = cfg.merged_ce && ce_port_en;

    // Route misses to the external strobes.
    always_comb begin
        ext_rd_stb   = 1'b0;
        ext_psen_stb = 1'b0;
        if (bus_req) begin
            if (bus_fetch) begin
                ext_psen_stb = !sram_code_sel;
            end else if (bus_rd && !int_hit) begin
                ext_psen_stb = merged_eff;
                ext_rd_stb   = !merged_eff;
            end
        end
    end

endmodule

// File: rtl/memmap_cfg.sv
// Top of the memory-map configuration block: timed-access sequencer,
// interlocked registers, read-back mux and address decode.
// Assumes a single register port shared by reads and writes of one master.
module memmap_cfg #(
    parameter int         ADDR_W      = 24,
    parameter int         REG_AW      = 8,
    parameter int         NUM_CAN     = 2,
    parameter int         WIN_CYCLES  = 4,
    parameter logic [7:0] CFG_ADDR    = 8'h20,
    parameter logic [7:0] STK_ADDR    = 8'h21,
    parameter logic [7:0] UNLOCK_ADDR = 8'h22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [REG_AW-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  logic               bus_req,
    input  logic               bus_fetch,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               ce_port_en,
    output logic               wide_stack,
    output logic               sram_data_sel,
    output logic               sram_code_sel,
    output logic [NUM_CAN-1:0] can_sel,
    output logic               ext_rd_stb,
    output logic               ext_psen_stb
);
    import memmap_pkg::*;

    logic    win_open;
    mm_cfg_t cfg;
    logic [7:0] cfg_byte;

    mm_unlock #(
        .REG_AW     (REG_AW),
        .UNLOCK_ADDR(UNLOCK_ADDR),
        .WIN_CYCLES (WIN_CYCLES)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .win_open(win_open)
    );

    mm_regs #(
        .REG_AW  (REG_AW),
        .CFG_ADDR(CFG_ADDR),
        .STK_ADDR(STK_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .win_open  (win_open),
        .cfg       (cfg),
        .wide_stack(wide_stack)
    );

    assign cfg_byte = cfg_to_byte(cfg);

    // Read-back mux; unmapped addresses read zero.
    always_comb begin
        if (rd_addr == REG_AW'(CFG_ADDR)) begin
            rd_data = cfg_byte;
        end else if (rd_addr == REG_AW'(STK_ADDR)) begin
            rd_data = {7'b0, wide_stack};
        end else begin
            rd_data = 8'h00;
        end
    end

    mm_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CAN(NUM_CAN)
    ) u_decode (
        .cfg          (cfg),
        .bus_req      (bus_req),
        .bus_fetch    (bus_fetch),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .ce_port_en   (ce_port_en),
        .sram_data_sel(sram_data_sel),
        .sram_code_sel(sram_code_sel),
        .can_sel      (can_sel),
        .ext_rd_stb   (ext_rd_stb),
        .ext_psen_stb (ext_psen_stb)
    );

endmodule

// File: rtl/memmap_cfg_chk.sv
// Property checker for memmap_cfg, attached by bind. Observes the register
// image, the window flag and the decode outputs.
module memmap_cfg_chk #(
    parameter int NUM_CAN = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_open,
    input logic [7:0]         cfg_byte,
    input logic               wide_stack,
    input logic               bus_req,
    input logic               bus_fetch,
    input logic               ce_port_en,
    input logic               sram_data_sel,
    input logic               sram_code_sel,
    input logic [NUM_CAN-1:0] can_sel,
    input logic               ext_rd_stb,
    input logic               ext_psen_stb
);

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> ($stable(cfg_byte) && $stable(wide_stack)));

    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_byte[4] && (cfg_byte[2:0] == 3'b000));

    // R5
    no_mode_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((cfg_byte[7:6] == 2'b11) && wide_stack));

    // R8
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_data_sel, sram_code_sel, can_sel}));

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd_stb && ext_psen_stb) && !((sram_data_sel || sram_code_sel || (|can_sel))
        && (ext_rd_stb || ext_psen_stb)));

    // R10
    merged_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_fetch && !ce_port_en) |-> !ext_psen_stb);

endmodule

bind memmap_cfg memmap_cfg_chk #(.NUM_CAN(NUM_CAN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_open     (win_open),
    .cfg_byte     (cfg_byte),
    .wide_stack   (wide_stack),
    .bus_req      (bus_req),
    .bus_fetch    (bus_fetch),
    .ce_port_en   (ce_port_en),
    .sram_data_sel(sram_data_sel),
    .sram_code_sel(sram_code_sel),
    .can_sel      (can_sel),
    .ext_rd_stb   (ext_rd_stb),
    .ext_psen_stb (ext_psen_stb)
);

// File: tb/memmap_cfg_tb.sv
`timescale 1ns/100ps
module memmap_cfg_tb;

    localparam logic [7:0] A_CFG = 8'h20;
    localparam logic [7:0] A_STK = 8'h21;
    localparam logic [7:0] A_UNL = 8'h22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        bus_req = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_rd = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        ce_port_en = 1'b0;
    logic        wide_stack;
    logic        sram_data_sel;
    logic        sram_code_sel;
    logic [1:0]  can_sel;
    logic        ext_rd_stb;
    logic        ext_psen_stb;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    memmap_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bus_req(bus_req), .bus_fetch(bus_fetch), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .ce_port_en(ce_port_en), .wide_stack(wide_stack),
        .sram_data_sel(sram_data_sel), .sram_code_sel(sram_code_sel),
        .can_sel(can_sel), .ext_rd_stb(ext_rd_stb), .ext_psen_stb(ext_psen_stb)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(A_UNL, 8'hAA);
        wr(A_UNL, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s reg %h: got %h expected %h", req, a, rd_data, exp);
        end
    endtask

    function automatic logic [7:0] cfg_img(input logic [7:0] d);
        return {d[7:6], d[5], 1'b1, d[3], 3'b000};
    endfunction

    // Expected decode: {sram_data, sram_code, can1, can0, ext_rd, ext_psen}
    function automatic logic [5:0] exp_dec(input logic [1:0] mode, input logic canhi,
                                           input logic merged, input logic ce,
                                           input logic req, input logic fetch,
                                           input logic rd, input logic [23:0] a);
        logic [11:0] base;
        logic [15:0] cp;
        logic sd, sc, c0, c1, hit, er, ep;
        base = (mode == 2'd0) ? 12'h00F : (mode == 2'd1) ? 12'h000 : 12'h400;
        cp   = canhi ? 16'h4010 : 16'h00EE;
        sd   = req && !fetch && (a[23:12] == base);
        sc   = req && fetch && (mode == 2'd3) && (a[23:12] == 12'h400);
        c0   = req && !fetch && (a[23:8] == cp);
        c1   = req && !fetch && (a[23:8] == cp + 16'd1);
        hit  = sd || c0 || c1;
        er   = req && !fetch && rd && !hit && !(merged && ce);
        ep   = req && (fetch ? !sc : (rd && !hit && merged && ce));
        return {sd, sc, c1, c0, er, ep};
    endfunction

    task automatic chk_dec(input logic [1:0] mode, input logic canhi, input logic merged);
        logic [5:0] got, exp;
        #0.5;
        got = {sram_data_sel, sram_code_sel, can_sel[1], can_sel[0], ext_rd_stb, ext_psen_stb};
        exp = exp_dec(mode, canhi, merged, ce_port_en, bus_req, bus_fetch, bus_rd, bus_addr);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R7 R8 R9 R10 R11 decode addr=%h f=%b r=%b: got %b expected %b",
                     bus_addr, bus_fetch, bus_rd, got, exp);
        end
        #0.5;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] hi_list [3];
        hi_list[0] = 8'h00; hi_list[1] = 8'h40; hi_list[2] = 8'h01;
        idle(3);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset image
        chk_reg(A_CFG, 8'h10, "R1");
        chk_reg(A_STK, 8'h00, "R1");
        chk_reg(A_UNL, 8'h00, "R1");

        // R3: writes without unlock are ignored
        wr(A_CFG, 8'hFF);
        wr(A_STK, 8'h01);
        chk_reg(A_CFG, 8'h10, "R3");
        chk_reg(A_STK, 8'h00, "R3");

        // R2 R3: every data value through an unlock
        for (int d = 0; d < 256; d++) begin
            unlock();
            wr(A_CFG, 8'(d));
            chk_reg(A_CFG, cfg_img(8'(d)), "R2");
        end
        unlock(); wr(A_STK, 8'hFE);
        chk_reg(A_STK, 8'h00, "R2");

        // R4: window edges and single-write rule
        unlock(); wr(A_CFG, 8'h40);
        unlock(); idle(3); wr(A_CFG, 8'h80);
        chk_reg(A_CFG, 8'h90, "R4 last window cycle");
        unlock(); idle(4); wr(A_CFG, 8'h40);
        chk_reg(A_CFG, 8'h90, "R4 window expired");
        unlock(); wr(A_CFG, 8'h00); wr(A_CFG, 8'h40);
        chk_reg(A_CFG, 8'h10, "R4 one write per unlock");
        wr(A_UNL, 8'hAA); idle(1); wr(A_UNL, 8'h55); wr(A_CFG, 8'h40);
        chk_reg(A_CFG, 8'h10, "R4 gap between keys");
        wr(A_UNL, 8'hAA); wr(A_CFG, 8'h55); wr(A_CFG, 8'h40);
        chk_reg(A_CFG, 8'h10, "R4 key at wrong address");
        unlock(); wr(A_STK, 8'h00); wr(A_CFG, 8'h40);
        chk_reg(A_CFG, 8'h10, "R4 stack write closes window");

        // R6: stack set refused in unified mode, allowed otherwise
        unlock(); wr(A_CFG, 8'hC0);
        unlock(); wr(A_STK, 8'h01);
        chk_reg(A_STK, 8'h00, "R6");
        chk_reg(A_CFG, 8'hD0, "R6");
        unlock(); wr(A_CFG, 8'h00);
        unlock(); wr(A_STK, 8'h01);
        chk_reg(A_STK, 8'h01, "R6");

        // R5: unified mode refused with wide stack, other fields land
        unlock(); wr(A_CFG, 8'hE8);
        chk_reg(A_CFG, 8'h38, "R5");
        unlock(); wr(A_CFG, 8'h88);
        chk_reg(A_CFG, 8'h98, "R5 non-unified accepted");
        unlock(); wr(A_STK, 8'h00);
        chk_reg(A_STK, 8'h00, "R6 clear accepted");

        // R11: no request, no strobes
        @(negedge clk);
        bus_req = 1'b0; bus_fetch = 1'b1; bus_addr = 24'h400000;
        chk_dec(2'd2, 1'b0, 1'b1);

        // R7 R8 R9 R10 R11: decode sweep over all configurations
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int g = 0; g < 2; g++) begin
                    unlock();
                    wr(A_CFG, {2'(m), 1'(c), 1'b0, 1'(g), 3'b000});
                    for (int e = 0; e < 2; e++) begin
                        ce_port_en = 1'(e);
                        bus_req = 1'b1;
                        for (int h = 0; h < 3; h++) begin
                            for (int p = 0; p < 256; p++) begin
                                for (int lo = 0; lo < 2; lo++) begin
                                    bus_addr = {hi_list[h], 8'(p), lo ? 8'hFF : 8'h00};
                                    bus_fetch = 1'b1; bus_rd = 1'b1;
                                    chk_dec(2'(m), 1'(c), 1'(g));
                                    bus_fetch = 1'b0; bus_rd = 1'b1;
                                    chk_dec(2'(m), 1'(c), 1'(g));
                                    bus_rd = 1'b0;
                                    chk_dec(2'(m), 1'(c), 1'(g));
                                end
                            end
                        end
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule